// File: doc/BRIEF.md
# Serial Shift and Shadow Configuration Register

This block holds the static configuration of a front-end chip. It keeps a serial shift chain apart from a bank of shadow latches. A controller shifts a new 53-bit setting in over a single data pin, one bit per rising clock edge. It then raises a load line, and the shadow bank takes the whole setting at once without a clock edge. The shadow outputs form the parallel configuration word that the chip's converters and switches use. The word stays steady while the chain shifts, holds or is read back.

Readback works the other way. One clocked copy moves the shadow contents back into the chain. The controller then shifts them out for checking, and the live configuration is not touched. The chain has one cell more than the data width. That extra last cell updates on the falling clock edge, so the serial output moves on falling edges and is stable around the next rising edge. This lets identical blocks be daisy-chained into a closed loop with the controller.

Top module: `cfg_shadow_chain`

## Requirements
- R1: Driving `rst_n` low at any time clears all shift cells, the last cell and all shadow latches at once, without waiting for a clock; `cfg_word` reads 0 and `ser_out` reads 0.
- R2: With `ctl_load`=0, `ctl_down`=0 and `ctl_hold`=0 (shift), each rising edge moves every data cell one place toward the output: cell i+1 takes cell i and cell 0 takes `ser_in`. A bit sampled from `ser_in` at rising edge n appears on `ser_out` after the falling edge that follows rising edge n+52.
- R3: `ser_out` changes only on falling clock edges and stays steady across rising edges.
- R4: With `ctl_hold`=1, `ctl_down`=0 and `ctl_load`=0 (hold), a rising edge leaves every cell unchanged and `ser_in` is ignored, so the outgoing bit stream pauses and then resumes with no bit lost.
- R5: With `ctl_down`=1 and `ctl_load`=0 (readback), the next rising edge copies shadow bit i into data cell i for all 53 bits. The value of `ctl_hold` makes no difference.
- R6: A readback edge does not load the last cell, so `ser_out` keeps its old value across that edge. At the following falling edge the last cell takes the freshly loaded cell 52.
- R7: While `ctl_load`=1, each shadow latch is transparent and `cfg_word` follows the data cells with no clock edge needed.
- R8: While `ctl_load`=0, `cfg_word` does not change, whatever shifting, holding or readback happens in the chain.
- R9: The control lines decode in priority order: load first, then readback, then hold, then shift. On a rising edge with `ctl_load`=1 the chain neither shifts nor reloads.
- R10: Two blocks sharing clock and control lines, with the first block's `ser_out` feeding the second block's `ser_in`, carry a 106-bit pattern end to end. A bit sampled by the first block at rising edge n appears on the second block's `ser_out` after the falling edge that follows rising edge n+105.
- R11: `cfg_word[i]` is the shadow of data cell i, and cell 0 is nearest `ser_in`. The first of 53 shifted bits therefore lands in `cfg_word[52]`. After a readback, `cfg_word[52]` is the first bit presented on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; data cells use the rising edge, the last cell uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of chain and shadow |
| ser_in | input | 1 | Serial data into cell 0 |
| ctl_hold | input | 1 | Hold request, active high |
| ctl_down | input | 1 | Readback request (shadow to chain), active high |
| ctl_load | input | 1 | Shadow latch enable (chain to shadow), level sensitive, active high |
| ser_out | output | 1 | Serial data from the last cell, changes on falling edges |
| cfg_word | output | 53 | Parallel configuration word from the shadow latches |

## Verification
The interesting overlaps are a load pulse held across a rising edge while the chain is mid-readback, and a readback edge asserted together with hold. Both are provoked in the middle of a serial readback. Under load the bench expects the outgoing stream to freeze for one cycle, and `cfg_word` to become the partly shifted chain image at that instant. Under readback with hold, it expects the shadow image to be copied while `ser_out` keeps its old bit until the next falling edge. A scoreboard checks every readback bit against the word that was written, so a slipped, repeated or lost bit shows up as a mismatch.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

    // Chain operation after priority decode of the three control lines.
    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_HOLD  = 2'd1,
        OP_DOWN  = 2'd2,
        OP_LOAD  = 2'd3
    } chain_op_t;

endpackage

// File: rtl/cfg_op_decode.sv
module cfg_op_decode
    import cfg_chain_pkg::*;
(
    input  logic      ctl_hold,
    input  logic      ctl_down,
    input  logic      ctl_load,
    output chain_op_t op
);

    // Priority: load, then readback, then hold, else shift (R9).
    always_comb begin
        if (ctl_load) begin
            op = OP_LOAD;
        end else if (ctl_down) begin
            op = OP_DOWN;
        end else if (ctl_hold) begin
            op = OP_HOLD;
        end else begin
            op = OP_SHIFT;
        end
    end

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
    import cfg_chain_pkg::*;
#(
    parameter int DATA_BITS = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  chain_op_t            op,
    input  logic                 ser_in,
    input  logic [DATA_BITS-1:0] shadow_in,
    output logic [DATA_BITS-1:0] chain_out,
    output logic                 ser_out
);

    localparam int TOP = DATA_BITS - 1;

    typedef struct packed {
        logic [DATA_BITS-1:0] cells;  // rising-edge data cells, cell 0 nearest ser_in
        logic                 take;   // last cell follows cell TOP at next falling edge
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic         fin_d, fin_q;

    // Next state of the rising-edge cells.
    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_SHIFT: begin
                st_d.cells = {st_q.cells[TOP-1:0], ser_in};
                st_d.take  = 1'b1;
            end
            OP_DOWN: begin
                st_d.cells = shadow_in;
                st_d.take  = 1'b1;  // last cell is skipped by the copy (R6)
            end
            OP_HOLD: begin
                st_d.take  = 1'b0;
            end
            default: begin          // OP_LOAD freezes the chain (R9)
                st_d.take  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Last cell: opposite edge, so ser_out moves on falling edges (R3).
    always_comb begin
        fin_d = fin_q;
        if (st_q.take) begin
            fin_d = st_q.cells[TOP];
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
        end else begin
            fin_q <= fin_d;
        end
    end

    assign chain_out = st_q.cells;
    assign ser_out   = fin_q;

    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (st_q.cells == {$past(st_q.cells[TOP-1:0]), $past(ser_in)}));

    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(st_q.cells));

    a_r5_down_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN) |=> (st_q.cells == $past(shadow_in)));

    a_r9_load_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> $stable(st_q.cells));

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
    parameter int DATA_BITS = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] chain_in,
    output logic [DATA_BITS-1:0] cfg_out
);

    // One level-sensitive latch per data bit (R7).
    for (genvar i = 0; i < DATA_BITS; i++) begin : g_latch
        logic cell_q;
        always_latch begin
            if (!rst_n) begin
                cell_q = 1'b0;
            end else if (load) begin
                cell_q = chain_in[i];
            end
        end
        assign cfg_out[i] = cell_q;
    end

    a_r8_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(!load)) |-> $stable(cfg_out));

endmodule

// File: rtl/cfg_shadow_chain.sv
module cfg_shadow_chain
    import cfg_chain_pkg::*;
#(
    parameter int DATA_BITS = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  logic                 ctl_hold,
    input  logic                 ctl_down,
    input  logic                 ctl_load,
    output logic                 ser_out,
    output logic [DATA_BITS-1:0] cfg_word
);

    chain_op_t            op;
    logic [DATA_BITS-1:0] chain_bits;

    cfg_op_decode u_dec (
        .ctl_hold (ctl_hold),
        .ctl_down (ctl_down),
        .ctl_load (ctl_load),
        .op       (op)
    );

    cfg_shift_chain #(.DATA_BITS(DATA_BITS)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ser_in    (ser_in),
        .shadow_in (cfg_word),
        .chain_out (chain_bits),
        .ser_out   (ser_out)
    );

    cfg_shadow_bank #(.DATA_BITS(DATA_BITS)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl_load),
        .chain_in (chain_bits),
        .cfg_out  (cfg_word)
    );

endmodule

// File: tb/cfg_shadow_chain_tb_top.sv
module cfg_shadow_chain_tb_top;

    localparam int NB = 53;
    localparam logic [NB-1:0] W1 = 53'h1_6A5C_3F09_D2E7;

    typedef struct {
        int            due;
        int            kind;   // 0: first ser_out, 1: second ser_out
        logic [NB-1:0] val;
        string         tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
    logic hold = 1'b0, down = 1'b0, load = 1'b0;
    logic a_out, b_out;
    logic [NB-1:0] cfg_a, cfg_b;
    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    cfg_shadow_chain #(.DATA_BITS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ctl_hold(hold),
        .ctl_down(down), .ctl_load(load), .ser_out(a_out), .cfg_word(cfg_a));

    cfg_shadow_chain #(.DATA_BITS(NB)) dut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(a_out), .ctl_hold(hold),
        .ctl_down(down), .ctl_load(load), .ser_out(b_out), .cfg_word(cfg_b));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int due, input int kind, input logic [NB-1:0] v, input string tag);
        exp_t e;
        e.due = due; e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input logic s, input logic h, input logic d, input logic l);
        ser_in = s; hold = h; down = d; load = l;
        @(posedge clk);
        #5;
    endtask

    // Monitor: samples 3 ns before each rising edge.
    always @(negedge clk) begin
        #7;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                if (sb[i].kind == 0) chk(sb[i].tag, {52'b0, a_out}, sb[i].val);
                else                 chk(sb[i].tag, {52'b0, b_out}, sb[i].val);
                sb.delete(i);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired (all requirements) act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] w2;
        logic          pv;
        logic [15:0]   lfsr;
        int            d;
        int            k;

        #3;
        chk("R1 reset cfg_a", cfg_a, '0);
        chk("R1 reset cfg_b", cfg_b, '0);
        chk("R1 reset ser_out", {52'b0, a_out}, '0);
        @(posedge clk); #5;
        rst_n = 1'b1;

        // Write W1: first bit sent is W1[52] (R11).
        for (int t = 0; t < NB; t++) step(W1[NB-1-t], 1'b0, 1'b0, 1'b0);
        ser_in = 1'b0; hold = 1'b0; down = 1'b0; load = 1'b1;
        #1;
        chk("R7 R11 shadow follows chain without clock", cfg_a, W1);
        chk("R7 second block shadow", cfg_b, '0);
        @(posedge clk); #5;
        load = 1'b0;

        // Shift ones; shadow must stay (R8).
        for (int t = 0; t < 20; t++) step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 shadow steady while shifting", cfg_a, W1);

        // Readback with hold also high: readback wins (R5, R9).
        pv = a_out;
        d = cyc + 1;
        push(d, 0, {52'b0, W1[NB-1]}, "R5 R11 first readback bit");
        step(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 ser_out kept across readback edge", {52'b0, a_out}, {52'b0, pv});
        chk("R8 readback leaves shadow", cfg_a, W1);
        #10;
        chk("R6 last cell takes cell 52 at falling edge", {52'b0, a_out}, {52'b0, W1[NB-1]});

        k = 0;
        w2 = W1;
        for (int m = 1; m < NB; m++) begin
            if (m == 20) begin
                for (int h = 0; h < 3; h++) begin
                    d = cyc + 1;
                    push(d, 0, {52'b0, W1[NB-1-k]}, "R4 hold pauses stream");
                    step(1'b1, 1'b1, 1'b0, 1'b0);
                end
            end
            if (m == 30) begin
                d = cyc + 1;
                push(d, 0, {52'b0, W1[NB-1-k]}, "R9 load freezes chain");
                ser_in = 1'b1; hold = 1'b0; down = 1'b0; load = 1'b1;
                #1;
                w2 = W1 << k;
                chk("R7 shadow takes partly shifted chain", cfg_a, w2);
                @(posedge clk); #5;
                load = 1'b0;
            end
            d = cyc + 1;
            k = m;
            push(d, 0, {52'b0, W1[NB-1-k]}, "R5 R2 readback stream");
            step(1'b0, 1'b0, 1'b0, 1'b0);
            if (m == 1) begin
                chk("R3 ser_out steady after rising edge", {52'b0, a_out}, {52'b0, W1[NB-1]});
                #10;
                chk("R3 ser_out moves at falling edge", {52'b0, a_out}, {52'b0, W1[NB-2]});
            end
        end
        chk("R8 shadow steady after readback", cfg_a, w2);

        // Daisy chain, 106-bit pattern (R10).
        lfsr = 16'hACE1;
        for (int t = 0; t < 106; t++) begin
            d = cyc + 1;
            push(d + 52, 0, {52'b0, lfsr[0]}, "R2 first block latency");
            push(d + 105, 1, {52'b0, lfsr[0]}, "R10 chained pattern");
            step(lfsr[0], 1'b0, 1'b0, 1'b0);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        for (int t = 0; t < 112; t++) step(1'b0, 1'b0, 1'b0, 1'b0);

        // Asynchronous clear mid-cycle (R1).
        rst_n = 1'b0;
        #1;
        chk("R1 async clear cfg_a", cfg_a, '0);
        chk("R1 async clear ser_out", {52'b0, a_out}, '0);
        chk("R1 async clear second block", {52'b0, b_out}, '0);
        @(posedge clk); #5;
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);

        foreach (sb[i]) begin
            total++; bad++;
            $display("FAIL %s act=unchecked exp=due %0d", sb[i].tag, sb[i].due);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule